// File: doc/BRIEF.md
# Floating-Tap Decision Feedback Equalizer

This block cancels postcursor intersymbol interference using only a few feedback taps. Each tap can sit at any symbol delay within a long history of past decisions. The taps are not fixed to consecutive postcursors. Before normal operation, a characterization source streams one ISI magnitude estimate per symbol delay into the block. The block keeps a ranked list of the delays with the strongest interference and assigns its taps to them.

Raising the init-done control freezes that assignment for the rest of the run. After that point, every incoming sample has the weighted contributions of the chosen past decisions removed. The equalized value and the sliced decision come out one cycle later. Software-style coefficient registers give each ranked tap its own signed weight. A tap whose rank was never filled stays disabled and contributes nothing.

Top module: `ftdfe_top`

## Requirements
- R1: While reset is held and directly after it, `outValid`, `locked` and every bit of `tapEn` are 0. All stored decisions read as 0, and all coefficients are 0.
- R2: Accepted estimates are numbered in arrival order from 0. Estimate k belongs to the decision taken k+1 samples before the current one, so position code k selects that decision. At most HIST_LEN estimates are accepted, and any further strobes leave `tapPos`/`tapEn` unchanged.
- R3: The enabled taps hold the delays with the largest nonzero magnitudes, ranked in descending order. Rank 0 is in the lowest POS_W bits of `tapPos`, and rank i is in bits [i*POS_W +: POS_W]. When two magnitudes are equal, the smaller delay takes the higher rank.
- R4: A delay with zero magnitude is never selected. If fewer than NUM_TAPS delays have a nonzero magnitude, only the lowest ranks are enabled. The unfilled ranks have `tapEn` 0 and add nothing to the output, whatever their coefficient.
- R5: No two enabled taps ever hold the same position.
- R6: A cycle with `initDone` high sets `locked` at the next edge, and `locked` stays set until reset. An estimate strobed in that same cycle is still accepted. Estimates strobed in later cycles are ignored, and `tapPos`/`tapEn` stay constant while locked.
- R7: While `locked` is 0, `eqOut` equals the sign-extended `sampleIn` of the previous cycle.
- R8: While `locked` is 1, `eqOut` equals `sampleIn` minus the sum over the enabled taps of +coef when the selected past decision is 1, or −coef when it is 0. `decOut` is 1 exactly when that result is greater than or equal to zero.
- R9: A new decision enters the history only when `sampleValid` is high, and it becomes the decision at delay code 0 for the next valid sample. Cycles without a valid sample leave the history unchanged.
- R10: With `coefWe` high, `coefData` is written to the coefficient of rank `coefSel`. The new value applies to samples presented in later cycles, and a sample presented in the same cycle as the write uses the old value.
- R11: `outValid` equals `sampleValid` delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| charValid | input | 1 | Strobe for one ISI magnitude estimate |
| charMag | input | MAG_W | Unsigned ISI magnitude for the next delay in order |
| initDone | input | 1 | Ends initialization and freezes tap positions |
| coefWe | input | 1 | Coefficient write strobe |
| coefSel | input | SEL_W | Rank of the tap whose coefficient is written |
| coefData | input | COEF_W | Signed coefficient value |
| sampleValid | input | 1 | Incoming sample strobe |
| sampleIn | input | SAMP_W | Signed incoming sample |
| outValid | output | 1 | Equalized result valid |
| eqOut | output | ACC_W | Signed equalized sample |
| decOut | output | 1 | Sliced decision of the equalized sample |
| locked | output | 1 | Tap positions frozen |
| tapPos | output | NUM_TAPS*POS_W | Ranked tap delay codes |
| tapEn | output | NUM_TAPS | Tap enables by rank |

## Verification
Each result has a fixed delay from its stimulus. The equalized sample, decision and valid flag appear one edge after the sample is presented. The ranked positions reflect an estimate one edge after its strobe, and `locked` rises one edge after `initDone`. A coefficient write is visible to samples presented from the next cycle on. The bench drives inputs one nanosecond after a rising edge. Its reference model advances on that rising edge, and every output is compared at the following falling edge, so each comparison sees exactly one register stage of latency. The per-edge comparisons run under named phases (ties, zero magnitudes, a partial load locked mid-stream, ignored late estimates, gaps between samples, mid-stream coefficient writes). Explicit checks at the end of each phase cover the exact packed positions and enables.

// File: rtl/ftdfe_pkg.sv
package ftdfe_pkg;
  localparam int HIST_LEN_DEF = 32;
  localparam int NUM_TAPS_DEF = 4;
  localparam int MAG_W_DEF    = 8;
  localparam int SAMP_W_DEF   = 10;
  localparam int COEF_W_DEF   = 8;

  // Strobes from the control unit to the ranking and cancellation logic
  typedef struct packed {
    logic loadEn;    // accept one magnitude estimate
    logic shiftEn;   // a sample is being equalized this cycle
    logic cancelEn;  // positions frozen, subtract tap terms
    logic coefWr;    // coefficient register write
  } ftdfe_strobe_t;
endpackage

// File: rtl/ftdfe_ctrl.sv
module ftdfe_ctrl
  import ftdfe_pkg::*;
#(
  parameter int HIST_LEN = HIST_LEN_DEF,
  localparam int POS_W   = $clog2(HIST_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             charValid,
  input  logic             initDone,
  input  logic             sampleValid,
  input  logic             coefWe,
  output ftdfe_strobe_t    strobe,
  output logic [POS_W-1:0] loadPos,
  output logic             locked
);
  localparam logic [POS_W:0] LOAD_LIMIT = (POS_W+1)'(HIST_LEN);

  logic [POS_W:0] loadCnt;
  logic           loadOk;

  assign loadOk  = charValid && !locked && (loadCnt < LOAD_LIMIT);
  assign loadPos = loadCnt[POS_W-1:0];

  always_comb begin
    strobe.loadEn   = loadOk;
    strobe.shiftEn  = sampleValid;
    strobe.cancelEn = locked;
    strobe.coefWr   = coefWe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadCnt <= '0;
      locked  <= 1'b0;
    end else begin
      if (loadOk) loadCnt <= loadCnt + 1'b1;
      if (initDone) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/ftdfe_rank.sv
module ftdfe_rank #(
  parameter int HIST_LEN = 32,
  parameter int NUM_TAPS = 4,
  parameter int MAG_W    = 8,
  localparam int POS_W   = $clog2(HIST_LEN)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      loadEn,
  input  logic [POS_W-1:0]          loadPos,
  input  logic [MAG_W-1:0]          loadMag,
  output logic [NUM_TAPS*POS_W-1:0] posFlat,
  output logic [NUM_TAPS-1:0]       enVec
);
  logic [MAG_W-1:0] slotMag [NUM_TAPS];
  logic [POS_W-1:0] slotPos [NUM_TAPS];
  logic [NUM_TAPS-1:0] slotVld;
  logic [NUM_TAPS-1:0] beats;

  // A strictly larger nonzero magnitude beats a slot; equal does not, so the
  // earlier (smaller) delay keeps the higher rank.
  always_comb begin
    for (int j = 0; j < NUM_TAPS; j++)
      beats[j] = (loadMag != '0) && (!slotVld[j] || (loadMag > slotMag[j]));
  end

  for (genvar j = 0; j < NUM_TAPS; j++) begin : gSlot
    if (j == 0) begin : gHead
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotMag[j] <= '0;
          slotPos[j] <= '0;
          slotVld[j] <= 1'b0;
        end else if (loadEn && beats[j]) begin
          slotMag[j] <= loadMag;
          slotPos[j] <= loadPos;
          slotVld[j] <= 1'b1;
        end
      end
    end else begin : gBody
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotMag[j] <= '0;
          slotPos[j] <= '0;
          slotVld[j] <= 1'b0;
        end else if (loadEn && beats[j]) begin
          if (beats[j-1]) begin
            slotMag[j] <= slotMag[j-1];
            slotPos[j] <= slotPos[j-1];
            slotVld[j] <= slotVld[j-1];
          end else begin
            slotMag[j] <= loadMag;
            slotPos[j] <= loadPos;
            slotVld[j] <= 1'b1;
          end
        end
      end
    end
    assign posFlat[j*POS_W +: POS_W] = slotPos[j];
  end

  assign enVec = slotVld;
endmodule

// File: rtl/ftdfe_dpath.sv
module ftdfe_dpath
  import ftdfe_pkg::*;
#(
  parameter int HIST_LEN = HIST_LEN_DEF,
  parameter int NUM_TAPS = NUM_TAPS_DEF,
  parameter int SAMP_W   = SAMP_W_DEF,
  parameter int COEF_W   = COEF_W_DEF,
  localparam int POS_W   = $clog2(HIST_LEN),
  localparam int SEL_W   = $clog2(NUM_TAPS),
  localparam int ACC_W   = SAMP_W + $clog2(NUM_TAPS + 1) + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ftdfe_strobe_t             strobe,
  input  logic [SEL_W-1:0]          coefSel,
  input  logic [COEF_W-1:0]         coefData,
  input  logic [SAMP_W-1:0]         sampleIn,
  input  logic [NUM_TAPS*POS_W-1:0] posFlat,
  input  logic [NUM_TAPS-1:0]       enVec,
  output logic                      outValid,
  output logic [ACC_W-1:0]          eqOut,
  output logic                      decOut
);
  logic [HIST_LEN-1:0] hist;
  logic [COEF_W-1:0]   coef [NUM_TAPS];
  logic [ACC_W-1:0]    term [NUM_TAPS];
  logic [ACC_W-1:0]    tapSum;
  logic [ACC_W-1:0]    sampleExt;
  logic [ACC_W-1:0]    eqNext;
  logic                decNext;

  // One selector per floating tap: route the chosen past decision
  for (genvar i = 0; i < NUM_TAPS; i++) begin : gTap
    logic [POS_W-1:0] tapIdx;
    logic             tapBit;
    logic [ACC_W-1:0] coefExt;
    assign tapIdx  = posFlat[i*POS_W +: POS_W];
    assign tapBit  = hist[tapIdx];
    assign coefExt = {{(ACC_W-COEF_W){coef[i][COEF_W-1]}}, coef[i]};
    always_comb begin
      if (strobe.cancelEn && enVec[i])
        term[i] = tapBit ? coefExt : (ACC_W'(0) - coefExt);
      else
        term[i] = '0;
    end
  end

  always_comb begin
    tapSum = '0;
    for (int i = 0; i < NUM_TAPS; i++) tapSum = tapSum + term[i];
  end

  assign sampleExt = {{(ACC_W-SAMP_W){sampleIn[SAMP_W-1]}}, sampleIn};
  assign eqNext    = sampleExt - tapSum;
  assign decNext   = ~eqNext[ACC_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist     <= '0;
      outValid <= 1'b0;
      eqOut    <= '0;
      decOut   <= 1'b0;
      for (int i = 0; i < NUM_TAPS; i++) coef[i] <= '0;
    end else begin
      outValid <= strobe.shiftEn;
      if (strobe.shiftEn) begin
        eqOut  <= eqNext;
        decOut <= decNext;
        hist   <= {hist[HIST_LEN-2:0], decNext};
      end
      if (strobe.coefWr) coef[coefSel] <= coefData;
    end
  end
endmodule

// File: rtl/ftdfe_top.sv
module ftdfe_top
  import ftdfe_pkg::*;
#(
  parameter int HIST_LEN = HIST_LEN_DEF,
  parameter int NUM_TAPS = NUM_TAPS_DEF,
  parameter int MAG_W    = MAG_W_DEF,
  parameter int SAMP_W   = SAMP_W_DEF,
  parameter int COEF_W   = COEF_W_DEF,
  localparam int POS_W   = $clog2(HIST_LEN),
  localparam int SEL_W   = $clog2(NUM_TAPS),
  localparam int ACC_W   = SAMP_W + $clog2(NUM_TAPS + 1) + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      charValid,
  input  logic [MAG_W-1:0]          charMag,
  input  logic                      initDone,
  input  logic                      coefWe,
  input  logic [SEL_W-1:0]          coefSel,
  input  logic [COEF_W-1:0]         coefData,
  input  logic                      sampleValid,
  input  logic [SAMP_W-1:0]         sampleIn,
  output logic                      outValid,
  output logic [ACC_W-1:0]          eqOut,
  output logic                      decOut,
  output logic                      locked,
  output logic [NUM_TAPS*POS_W-1:0] tapPos,
  output logic [NUM_TAPS-1:0]       tapEn
);
  ftdfe_strobe_t    strobe;
  logic [POS_W-1:0] loadPos;

  ftdfe_ctrl #(.HIST_LEN(HIST_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .charValid(charValid), .initDone(initDone),
    .sampleValid(sampleValid), .coefWe(coefWe), .strobe(strobe),
    .loadPos(loadPos), .locked(locked)
  );

  ftdfe_rank #(.HIST_LEN(HIST_LEN), .NUM_TAPS(NUM_TAPS), .MAG_W(MAG_W)) uRank (
    .clk(clk), .rstN(rstN), .loadEn(strobe.loadEn), .loadPos(loadPos),
    .loadMag(charMag), .posFlat(tapPos), .enVec(tapEn)
  );

  ftdfe_dpath #(.HIST_LEN(HIST_LEN), .NUM_TAPS(NUM_TAPS), .SAMP_W(SAMP_W),
                .COEF_W(COEF_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .coefSel(coefSel),
    .coefData(coefData), .sampleIn(sampleIn), .posFlat(tapPos), .enVec(tapEn),
    .outValid(outValid), .eqOut(eqOut), .decOut(decOut)
  );
endmodule

// File: rtl/ftdfe_chk.sv
module ftdfe_chk #(
  parameter int HIST_LEN = 32,
  parameter int NUM_TAPS = 4,
  parameter int SAMP_W   = 10,
  localparam int POS_W   = $clog2(HIST_LEN),
  localparam int ACC_W   = SAMP_W + $clog2(NUM_TAPS + 1) + 1
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      initDone,
  input logic                      sampleValid,
  input logic [SAMP_W-1:0]         sampleIn,
  input logic                      outValid,
  input logic [ACC_W-1:0]          eqOut,
  input logic                      locked,
  input logic [NUM_TAPS*POS_W-1:0] tapPos,
  input logic [NUM_TAPS-1:0]       tapEn
);
  logic dupPos;
  always_comb begin
    dupPos = 1'b0;
    for (int a = 0; a < NUM_TAPS; a++)
      for (int b = a + 1; b < NUM_TAPS; b++)
        if (tapEn[a] && tapEn[b] &&
            (tapPos[a*POS_W +: POS_W] == tapPos[b*POS_W +: POS_W]))
          dupPos = 1'b1;
  end

  AST_UNIQUE_POS: assert property (@(posedge clk) disable iff (!rstN) !dupPos); // R5
  AST_EN_PREFIX: assert property (@(posedge clk) disable iff (!rstN)
    ((tapEn & (tapEn + 1'b1)) == '0)); // R4
  AST_INIT_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> locked); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked); // R6
  AST_POS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> ($stable(tapPos) && $stable(tapEn))); // R6
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> outValid); // R11
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !outValid); // R11
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && sampleValid) |=> ($signed(eqOut) == $signed($past(sampleIn)))); // R7
endmodule

bind ftdfe_top ftdfe_chk #(.HIST_LEN(HIST_LEN), .NUM_TAPS(NUM_TAPS), .SAMP_W(SAMP_W)) uChk (
  .clk(clk), .rstN(rstN), .initDone(initDone), .sampleValid(sampleValid),
  .sampleIn(sampleIn), .outValid(outValid), .eqOut(eqOut), .locked(locked),
  .tapPos(tapPos), .tapEn(tapEn)
);

// File: tb/sim_ftdfe_top.sv
`timescale 1ns/100ps
module sim_ftdfe_top;
  localparam int HL = 32, NT = 4, MW = 8, SW = 10, CW = 8;
  localparam int PW = 5, SLW = 2, AW = SW + 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic charValid = 1'b0;
  logic [MW-1:0] charMag = '0;
  logic initDone = 1'b0;
  logic coefWe = 1'b0;
  logic [SLW-1:0] coefSel = '0;
  logic [CW-1:0] coefData = '0;
  logic sampleValid = 1'b0;
  logic [SW-1:0] sampleIn = '0;
  logic outValid, decOut, locked;
  logic [AW-1:0] eqOut;
  logic [NT*PW-1:0] tapPos;
  logic [NT-1:0] tapEn;

  ftdfe_top u0 (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charMag(charMag),
    .initDone(initDone), .coefWe(coefWe), .coefSel(coefSel), .coefData(coefData),
    .sampleValid(sampleValid), .sampleIn(sampleIn), .outValid(outValid),
    .eqOut(eqOut), .decOut(decOut), .locked(locked), .tapPos(tapPos), .tapEn(tapEn)
  );

  always #2 clk = ~clk;  // 250 MHz

  int nChecks = 0, nFails = 0, cycles = 0;
  string phase = "R1";

  // Behavioural reference state
  int mMag[HL];
  bit mHist[HL];
  int mCoef[NT];
  bit mLocked;
  int mCnt;
  bit expValid, expDec, expLocked;
  int expEq;
  logic [NT*PW-1:0] expPos;
  logic [NT-1:0] expEn;

  task automatic check(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void pickTop(output int p[NT], output bit e[NT]);
    bit used[HL];
    for (int k = 0; k < HL; k++) used[k] = 0;
    for (int s = 0; s < NT; s++) begin
      int best = -1;
      for (int k = 0; k < HL; k++)
        if (!used[k] && mMag[k] > 0 && (best < 0 || mMag[k] > mMag[best])) best = k;
      e[s] = (best >= 0);
      p[s] = (best >= 0) ? best : 0;
      if (best >= 0) used[best] = 1;
    end
  endfunction

  always @(posedge clk) begin
    int p[NT];
    bit e[NT];
    cycles++;
    if (!rstN) begin
      for (int k = 0; k < HL; k++) begin mMag[k] = 0; mHist[k] = 0; end
      for (int t = 0; t < NT; t++) mCoef[t] = 0;
      mLocked = 0; mCnt = 0; expValid = 0; expEq = 0; expDec = 0;
    end else begin
      int eq;
      pickTop(p, e);
      eq = $signed(sampleIn);
      if (mLocked)
        for (int t = 0; t < NT; t++)
          if (e[t]) eq -= mHist[p[t]] ? mCoef[t] : -mCoef[t];
      expValid = sampleValid;
      if (sampleValid) begin
        expEq = eq; expDec = (eq >= 0);
        for (int k = HL - 1; k > 0; k--) mHist[k] = mHist[k-1];
        mHist[0] = (eq >= 0);
      end
      if (coefWe) mCoef[coefSel] = $signed(coefData);
      if (charValid && !mLocked && mCnt < HL) begin mMag[mCnt] = charMag; mCnt++; end
      if (initDone) mLocked = 1;
    end
    pickTop(p, e);
    for (int t = 0; t < NT; t++) begin
      expPos[t*PW +: PW] = PW'(p[t]);
      expEn[t] = e[t];
    end
    expLocked = mLocked;
  end

  always @(negedge clk) begin
    if (rstN) begin
      check({phase, " R11 valid"}, outValid, expValid);
      if (expValid) begin
        check({phase, " eq"}, $signed(eqOut), expEq);
        check({phase, " dec"}, decOut, expDec);
      end
      check({phase, " locked"}, locked, expLocked);
      check({phase, " pos"}, tapPos, expPos);
      check({phase, " en"}, tapEn, expEn);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    charValid = 0; initDone = 0; coefWe = 0; sampleValid = 0;
  endtask

  task automatic writeCoef(int sel, int val);
    coefWe = 1; coefSel = SLW'(sel); coefData = CW'(val);
  endtask

  task automatic runSamples(int n, int seed, bit gaps);
    for (int i = 0; i < n; i++) begin
      sampleValid = gaps ? (((i * 7 + seed) % 3) != 0) : 1'b1;
      sampleIn = SW'(((i * 37 + seed * 11) % 700) - 350);
      step();
    end
    idle(); step();
  endtask

  function automatic logic [NT*PW-1:0] packPos(int a, int b, int c, int d);
    return {PW'(d), PW'(c), PW'(b), PW'(a)};
  endfunction

  initial begin
    repeat (3) step();
    // R1: state under reset
    check("R1 outValid", outValid, 0);
    check("R1 locked", locked, 0);
    check("R1 tapEn", tapEn, 0);
    rstN = 1; step();
    check("R1 tapEn after release", tapEn, 0);

    // R7 and R10: samples pass unchanged before lock, coefficients are written
    phase = "R7";
    writeCoef(0, 40); sampleValid = 1; sampleIn = SW'(-100); step();
    writeCoef(1, -25); step();
    writeCoef(2, 18); step();
    writeCoef(3, 7); sampleValid = 0; step();
    idle();
    runSamples(20, 3, 1);

    // R2/R3: 32 estimates with ties and zeros
    phase = "R3";
    for (int k = 0; k < HL; k++) begin
      int m;
      case (k)
        3: m = 50; 7: m = 80; 12: m = 50; 20: m = 80; 25: m = 30;
        default: m = (k % 5 == 1) ? 10 : 0;
      endcase
      charValid = 1; charMag = MW'(m); step();
    end
    idle(); step();
    check("R3 ranked positions", tapPos, packPos(7, 20, 3, 12));
    check("R3 enables", tapEn, 4'b1111);
    phase = "R2";
    charValid = 1; charMag = 8'd255; step();
    idle(); step();
    check("R2 extra estimate ignored", tapPos, packPos(7, 20, 3, 12));

    // R6: lock, later estimates ignored
    phase = "R6";
    initDone = 1; step(); idle(); step();
    check("R6 locked", locked, 1);
    check("R6 positions held", tapPos, packPos(7, 20, 3, 12));

    // R8/R9: cancellation, with gaps between samples
    phase = "R8";
    runSamples(60, 5, 0);
    phase = "R9";
    runSamples(60, 9, 1);
    // R10: mid-stream coefficient writes
    phase = "R10";
    for (int i = 0; i < 30; i++) begin
      sampleValid = 1; sampleIn = SW'((i * 53) % 600 - 300);
      if (i % 4 == 0) writeCoef(i % NT, (i * 13) % 120 - 60); else coefWe = 0;
      step();
    end
    idle(); step();

    // R4 and R6: partial load, locked in the cycle of the last accepted estimate
    phase = "R4";
    rstN = 0; step(); step(); rstN = 1; step();
    check("R1 locked clear after reset", locked, 0);
    for (int k = 0; k < 11; k++) begin
      charValid = 1;
      charMag = (k == 5 || k == 9) ? 8'd9 : (k == 10 ? 8'd100 : 8'd0);
      initDone = (k == 10);
      step();
    end
    idle();
    charValid = 1; charMag = 8'd200; step();
    idle(); step();
    check("R6 estimate with initDone accepted", tapPos[PW-1:0], 10);
    check("R4 partial positions", tapPos[3*PW-1:0], packPos(10, 5, 9, 0) & 15'h7fff);
    check("R4 unfilled ranks disabled", tapEn, 4'b0111);
    writeCoef(3, 100); step();
    writeCoef(0, 30); step();
    writeCoef(1, -20); step();
    writeCoef(2, 12); step(); idle();
    runSamples(40, 13, 0);

    check("R1 run complete", 1, 1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected below 5000", cycles);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule